// File: doc/BRIEF.md
# Registered Command Buffer with Chip-Select Output Hold

This block sits in the address and command path of a registered memory module. On every rising edge of the clock it captures a 28-bit command word and drives each captured bit to two output copies, giving a 1-to-2 fan-out so that two groups of memory loads can be driven from one buffer. The word is split into three fields: a 22-bit shared data field, a 2-bit chip-select field and a 4-bit field of per-rank control bits for clock enable and on-die termination.

To save power while the module is idle, the data field can be frozen. When the gate-enable input and both chip-selects being captured are high, the data registers keep their contents, so neither data copy toggles. The chip-select and control fields are never frozen. An asynchronous active-low reset clears every register at once and has priority over the gating. A static mode input picks one of two bit assignments for the second data copy: it either mirrors the first copy or carries the data field in reversed bit order. The reversed order suits a module that routes the second copy along the opposite edge of the board.

Top module: `cmd_regbuf`

## Requirements
- R1: Driving rst_n low clears every output (q_a, q_b, sel_a, sel_b, ctl_a, ctl_b) to zero at once, without waiting for a clock edge.
- R2: While the data field is not held, q_a takes the value that d_in had at the latest rising clock edge.
- R3: With cfg_mode = 0, q_b equals q_a bit for bit.
- R4: With cfg_mode = 1, q_b[i] equals q_a[DATA_W-1-i] for every bit i.
- R5: At a rising edge where gate_en = 1 and sel_in = 2'b11, q_a and q_b keep their values.
- R6: At a rising edge where gate_en = 0, or where at least one bit of sel_in is 0, q_a and q_b update from d_in.
- R7: sel_a and sel_b both take sel_in, and ctl_a and ctl_b both take ctl_in, at every rising edge, including edges where the data field is held.
- R8: After rst_n rises, every output stays zero until the first rising clock edge that follows.
- R9: While rst_n is low, rising clock edges leave every output at zero, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Inputs are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Static bit-assignment select: 0 makes q_b mirror q_a, 1 reverses the bit order of q_b |
| gate_en | input | 1 | Allows chip-select gating of the data field |
| sel_in | input | 2 | Chip-select inputs, active low |
| ctl_in | input | 4 | Per-rank clock-enable and termination bits |
| d_in | input | 22 | Shared command and address data |
| q_a | output | 22 | Registered data, first copy |
| q_b | output | 22 | Registered data, second copy, ordered by cfg_mode |
| sel_a | output | 2 | Registered chip-selects, first copy |
| sel_b | output | 2 | Registered chip-selects, second copy |
| ctl_a | output | 4 | Registered control bits, first copy |
| ctl_b | output | 4 | Registered control bits, second copy |

## Verification
The clocked properties assume that cfg_mode stays constant between resets and that the inputs settle away from the rising edge, so the values sampled at an edge are the values that were captured. The bench changes cfg_mode only while rst_n is low, and it drives every input on the falling edge. Reset is asserted and released mid-cycle, away from both edges. This exercises the asynchronous behaviour of reset without creating a race at the capture edge.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;
   typedef enum logic {
      MAP_MIRROR  = 1'b0,
      MAP_REVERSE = 1'b1
   } map_mode_e;

   localparam int WORD_W = 28;
endpackage

// File: rtl/regbuf_gate.sv
module regbuf_gate #(
   parameter int SEL_W = 2
) (
   input  logic             gate_en,
   input  logic [SEL_W-1:0] sel_in,
   output logic             data_load
);
   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("regbuf_gate: SEL_W must be at least 1");
      end
   endgenerate

   logic all_idle;

   always_comb begin
      all_idle  = &sel_in;
      data_load = !(gate_en && all_idle);
   end
endmodule

// File: rtl/regbuf_lane.sv
module regbuf_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("regbuf_lane: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

   assert_lane_reset_R1: assert property (@(posedge clk) !rst_n |-> (q == '0))
      else $error("lane register not cleared during reset");
endmodule

// File: rtl/regbuf_map.sv
module regbuf_map
   import regbuf_pkg::*;
#(
   parameter int W = 8
) (
   input  map_mode_e    mode,
   input  logic [W-1:0] src,
   output logic [W-1:0] copy_a,
   output logic [W-1:0] copy_b
);
   generate
      if (W < 1) begin : g_bad_w
         $error("regbuf_map: W must be at least 1");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         localparam int MIRROR_IDX = W - 1 - i;
         always_comb begin
            copy_a[i] = src[i];
            copy_b[i] = (mode == MAP_REVERSE) ? src[MIRROR_IDX] : src[i];
         end
      end
   endgenerate
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
   import regbuf_pkg::*;
#(
   parameter int DATA_W = 22,
   parameter int SEL_W  = 2,
   parameter int CTL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              gate_en,
   input  logic [SEL_W-1:0]  sel_in,
   input  logic [CTL_W-1:0]  ctl_in,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] q_a,
   output logic [DATA_W-1:0] q_b,
   output logic [SEL_W-1:0]  sel_a,
   output logic [SEL_W-1:0]  sel_b,
   output logic [CTL_W-1:0]  ctl_a,
   output logic [CTL_W-1:0]  ctl_b
);
   localparam int SIDE_W = SEL_W + CTL_W;
   localparam int TOT_W  = DATA_W + SIDE_W;

   generate
      if (TOT_W != WORD_W) begin : g_bad_total
         $error("cmd_regbuf: field widths must add up to the word width");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("cmd_regbuf: DATA_W must be at least 2");
      end
   endgenerate

   logic              data_load;
   logic [DATA_W-1:0] data_q;
   logic [SIDE_W-1:0] side_q;
   map_mode_e         mode;

   assign mode = map_mode_e'(cfg_mode);

   regbuf_gate #(.SEL_W(SEL_W)) u_gate (
      .gate_en   (gate_en),
      .sel_in    (sel_in),
      .data_load (data_load)
   );

   regbuf_lane #(.W(DATA_W)) u_data (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (data_load),
      .d     (d_in),
      .q     (data_q)
   );

   regbuf_lane #(.W(SIDE_W)) u_side (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (1'b1),
      .d     ({ctl_in, sel_in}),
      .q     (side_q)
   );

   regbuf_map #(.W(DATA_W)) u_map (
      .mode   (mode),
      .src    (data_q),
      .copy_a (q_a),
      .copy_b (q_b)
   );

   always_comb begin
      sel_a = side_q[SEL_W-1:0];
      sel_b = side_q[SEL_W-1:0];
      ctl_a = side_q[SIDE_W-1:SEL_W];
      ctl_b = side_q[SIDE_W-1:SEL_W];
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |-> (q_a == '0 && q_b == '0 && sel_a == '0 && ctl_a == '0))
      else $error("outputs not cleared in reset");

   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_en && (&sel_in)) |=> (q_a == $past(d_in)))
      else $error("data copy A did not capture input");

   assert_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |-> (q_b == q_a))
      else $error("copy B differs from copy A in mirror mode");

   assert_reverse_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mode |-> (q_b[0] == q_a[DATA_W-1] && q_b[DATA_W-1] == q_a[0]))
      else $error("copy B end bits not reversed");

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && (&sel_in)) |=> ($stable(q_a) && $stable(q_b)))
      else $error("data changed while held");

   assert_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sel_b == $past(sel_in) && ctl_b == $past(ctl_in)))
      else $error("side fields not registered");
endmodule

// File: tb/cmd_regbuf_bench.sv
`timescale 1ns/1ps
module cmd_regbuf_bench;
   localparam int DW = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_mode = 1'b0;
   logic          gate_en = 1'b0;
   logic [1:0]    sel_in = 2'b00;
   logic [3:0]    ctl_in = 4'h0;
   logic [DW-1:0] d_in = '0;
   logic [DW-1:0] q_a, q_b;
   logic [1:0]    sel_a, sel_b;
   logic [3:0]    ctl_a, ctl_b;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   cmd_regbuf u_cmd_regbuf (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .gate_en(gate_en),
      .sel_in(sel_in), .ctl_in(ctl_in), .d_in(d_in),
      .q_a(q_a), .q_b(q_b), .sel_a(sel_a), .sel_b(sel_b),
      .ctl_a(ctl_a), .ctl_b(ctl_b)
   );

   function automatic logic [DW-1:0] rev(input logic [DW-1:0] v);
      logic [DW-1:0] r;
      for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [DW-1:0] d, input logic [1:0] s,
                       input logic [3:0] c, input logic ge);
      @(negedge clk);
      d_in = d; sel_in = s; ctl_in = c; gate_en = ge;
      @(posedge clk);
      #1;
   endtask

   task automatic all_zero(input string tag);
      check(tag, {10'd0, q_a}, 32'd0);
      check(tag, {10'd0, q_b}, 32'd0);
      check(tag, {24'd0, ctl_a, sel_a, sel_b}, 32'd0);
      check(tag, {28'd0, ctl_b}, 32'd0);
   endtask

   task automatic t_reset_state;
      #1 all_zero("R1 initial reset");
      @(posedge clk); #1 all_zero("R9 edge in reset");
   endtask

   task automatic t_release;
      @(negedge clk);
      d_in = 22'h2AAAAA; sel_in = 2'b01; ctl_in = 4'h9; gate_en = 1'b0;
      #1 rst_n = 1'b1;
      #0.5 all_zero("R8 after release");
      @(posedge clk); #1;
      check("R2 first capture", {10'd0, q_a}, 32'h2AAAAA);
      check("R7 sel after release", {30'd0, sel_a}, 32'd1);
   endtask

   task automatic t_mirror;
      step(22'h123456, 2'b00, 4'h3, 1'b0);
      check("R2 pattern1", {10'd0, q_a}, 32'h123456);
      check("R3 mirror1", {10'd0, q_b}, 32'h123456);
      step(22'h3FFFFF, 2'b10, 4'hC, 1'b1);
      check("R6 one sel low", {10'd0, q_a}, 32'h3FFFFF);
      check("R3 mirror2", {10'd0, q_b}, 32'h3FFFFF);
   endtask

   task automatic t_hold;
      step(22'h0F0F0F, 2'b00, 4'h1, 1'b1);
      check("R2 before hold", {10'd0, q_a}, 32'h0F0F0F);
      step(22'h30F0F0, 2'b11, 4'h6, 1'b1);
      check("R5 hold q_a", {10'd0, q_a}, 32'h0F0F0F);
      check("R5 hold q_b", {10'd0, q_b}, 32'h0F0F0F);
      check("R7 sel during hold", {28'd0, sel_a, sel_b}, 32'hF);
      check("R7 ctl during hold", {24'd0, ctl_a, ctl_b}, 32'h66);
      step(22'h111111, 2'b11, 4'hA, 1'b1);
      check("R5 hold second cycle", {10'd0, q_a}, 32'h0F0F0F);
      check("R7 ctl second hold", {24'd0, ctl_a, ctl_b}, 32'hAA);
      step(22'h222222, 2'b11, 4'h5, 1'b0);
      check("R6 gate_en low", {10'd0, q_a}, 32'h222222);
      step(22'h333333, 2'b01, 4'h5, 1'b1);
      check("R6 sel1 low", {10'd0, q_a}, 32'h333333);
   endtask

   task automatic t_async_reset;
      #0.5 rst_n = 1'b0;
      #0.5 all_zero("R1 async mid-cycle");
      step(22'h3FFFFF, 2'b00, 4'hF, 1'b0);
      all_zero("R9 edge with data in reset");
   endtask

   task automatic t_reverse;
      cfg_mode = 1'b1;
      @(negedge clk);
      d_in = 22'h000001; sel_in = 2'b00; ctl_in = 4'h0; gate_en = 1'b0;
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      check("R4 reverse single", {10'd0, q_b}, {10'd0, rev(22'h000001)});
      step(22'h2D3A41, 2'b10, 4'h2, 1'b0);
      check("R4 reverse pattern", {10'd0, q_b}, {10'd0, rev(22'h2D3A41)});
      check("R2 copy A unaffected", {10'd0, q_a}, 32'h2D3A41);
      step(22'h000000, 2'b11, 4'h2, 1'b1);
      check("R5 hold reversed", {10'd0, q_b}, {10'd0, rev(22'h2D3A41)});
   endtask

   initial begin
      t_reset_state();
      t_release();
      t_mirror();
      t_hold();
      t_async_reset();
      t_reverse();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #20000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule